// File: doc/BRIEF.md
# Processor Power-Mode Sequencer

This block moves a processor core between four power states, graded by what each one keeps running. In full power, every domain is clocked. Doze keeps bus snooping and the time base/decrementer alive. Nap keeps only the time base/decrementer. Sleep stops everything, including the internal clock regenerators. Software selects a state by writing a mode-control register. The register has a dynamic power management bit and three low-power request bits. The block then runs the entry sequence and drives the clock-enable outputs for each domain.

Nap and sleep drop bus snooping, so the block first raises a quiesce request. It waits for the system to acknowledge before it counts the entry delay and powers down. While in doze, a snoop hit starts a short copy-back excursion: the data cache is enabled until the copy-back finishes, and the block then drops back to doze. Any of four interrupt sources, or a soft reset, returns the core to full power within one cycle. The same event clears the pending requests so the core does not fall straight back into a low-power state. A wake from sleep raises a flag that says the time base must be reloaded.

The state machine has eight states, each visible on `pwr_state`:
- FULL (0)
- DOZE_ENTRY (1)
- DOZE (2)
- COPYBACK (3)
- QUIESCE (4)
- LOW_ENTRY (5)
- NAP (6)
- SLEEP (7)

Transitions:
- FULL→QUIESCE on a nap or sleep request.
- FULL→DOZE_ENTRY on a doze request.
- DOZE_ENTRY→DOZE when the delay expires.
- DOZE→COPYBACK on a snoop hit.
- COPYBACK→DOZE when the copy-back is done.
- QUIESCE→LOW_ENTRY on acknowledge.
- LOW_ENTRY→NAP or LOW_ENTRY→SLEEP when the delay expires.
- Any state other than FULL→FULL on a wake event.

Top module: `pwr_mode_seq`

## Requirements
- R1: After hard reset the state is FULL (0). All unit, snoop, time-base, data-cache, receiver and regenerator enables are 1, `qreq` is 0, `tb_reload` is 0 and the mode register reads 0.
- R2: In FULL with mode bit 11 (dynamic power management) set, `unit_clk_en` equals `unit_busy`, while snoop and time-base enables stay 1. With bit 11 clear, `unit_clk_en` is all ones.
- R3: Setting mode bit 8 (doze) moves FULL to DOZE_ENTRY on the next edge. The block stays there for ENTRY_DLY cycles and then enters DOZE. In DOZE the unit and data-cache enables are 0, and the snoop and time-base enables are 1.
- R4: In DOZE, `snoop_hit` moves the block to COPYBACK, where `dcache_en` is 1. It stays there until `copyback_done`, then returns to DOZE with `dcache_en` 0.
- R5: Setting mode bit 9 (nap) moves FULL to QUIESCE with `qreq` 1. The block waits there until `qack`, spends ENTRY_DLY cycles in LOW_ENTRY, and then enters NAP. In NAP the unit, snoop and receiver enables are 0, while the time-base and regenerator enables are 1.
- R6: Setting mode bit 10 (sleep) uses the same QUIESCE and LOW_ENTRY sequence and ends in SLEEP, where every enable output is 0.
- R7: When several request bits are set, sleep wins over nap, and nap wins over doze.
- R8: A wake event in any state other than FULL returns the block to FULL on the next edge. The wake events are `irq_ext`, `irq_smi`, `irq_mchk`, `irq_dec` and `soft_rst`.
- R9: A wake event in QUIESCE, before `qack`, abandons the request: the state becomes FULL and `qreq` drops to 0.
- R10: Any wake, and a soft reset in FULL, clears mode bits 10:8. Bit 11 is kept.
- R11: Leaving SLEEP sets `tb_reload`. It stays set until the next mode-register write.
- R12: `qreq` stays 1 from QUIESCE through LOW_ENTRY and NAP or SLEEP, until the wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| soft_rst | input | 1 | Soft reset pulse, a wake event |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 16 | Mode register write data |
| mode_rdata | output | 16 | Mode register contents (bits 11:8 used) |
| unit_busy | input | NUM_UNITS | Per-unit work pending |
| snoop_hit | input | 1 | Snoop hit needing copy-back |
| copyback_done | input | 1 | Copy-back finished |
| irq_ext | input | 1 | External interrupt |
| irq_smi | input | 1 | System-management interrupt |
| irq_mchk | input | 1 | Machine-check request |
| irq_dec | input | 1 | Decrementer interrupt |
| qack | input | 1 | Quiesce acknowledge from system |
| qreq | output | 1 | Quiesce request to system |
| unit_clk_en | output | NUM_UNITS | Execution unit clock enables |
| snoop_clk_en | output | 1 | Bus snoop logic clock enable |
| tb_clk_en | output | 1 | Time base/decrementer clock enable |
| dcache_en | output | 1 | Data cache enable |
| rcv_en | output | 1 | Nonessential input receiver enable |
| clkregen_en | output | 1 | Internal clock regenerator enable |
| tb_reload | output | 1 | Time base must be reloaded |
| pwr_state | output | 3 | Current state code |

## Verification
The bench sweeps every combination of request bits against every wake source. This exposes a wrong priority encoder, since it would land in nap or doze when sleep was also asked for. It also exposes a wake source that is left out of the wake OR, because the block would stay parked in a low-power state. Each wake source is also applied during the quiesce wait, where a design that ignored the abandon case would leave `qreq` high or carry on into LOW_ENTRY. The bench counts the entry delay cycle by cycle, so an off-by-one counter shows up as an early or late state change. It also checks `tb_reload` before and after the clearing write, and checks that bit 11 survives the request clear.

// File: rtl/pms_pkg.sv
package pms_pkg;
    typedef enum logic [2:0] {
        PS_FULL       = 3'd0,
        PS_DOZE_ENTRY = 3'd1,
        PS_DOZE       = 3'd2,
        PS_COPYBACK   = 3'd3,
        PS_QUIESCE    = 3'd4,
        PS_LOW_ENTRY  = 3'd5,
        PS_NAP        = 3'd6,
        PS_SLEEP      = 3'd7
    } pwr_state_e;

    localparam int MODE_W    = 16;
    localparam int DOZE_BIT  = 8;
    localparam int NAP_BIT   = 9;
    localparam int SLEEP_BIT = 10;
    localparam int DPM_BIT   = 11;
endpackage

// File: rtl/pms_req_reg.sv
module pms_req_reg
    import pms_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [MODE_W-1:0] wdata,
    input  logic              clr_req,
    output logic [MODE_W-1:0] rdata,
    output logic              dpm_en,
    output logic              want_doze,
    output logic              want_nap,
    output logic              want_sleep
);
    logic dpm_q, doze_q, nap_q, sleep_q;
    logic unused_bits;

    assign unused_bits = ^{wdata[MODE_W-1:DPM_BIT+1], wdata[DOZE_BIT-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dpm_q   <= 1'b0;
            doze_q  <= 1'b0;
            nap_q   <= 1'b0;
            sleep_q <= 1'b0;
        end else begin
            if (we) dpm_q <= wdata[DPM_BIT];
            if (clr_req) begin
                doze_q  <= 1'b0;
                nap_q   <= 1'b0;
                sleep_q <= 1'b0;
            end else if (we) begin
                doze_q  <= wdata[DOZE_BIT];
                nap_q   <= wdata[NAP_BIT];
                sleep_q <= wdata[SLEEP_BIT];
            end
        end
    end

    always_comb begin
        rdata            = '0;
        rdata[DPM_BIT]   = dpm_q;
        rdata[SLEEP_BIT] = sleep_q;
        rdata[NAP_BIT]   = nap_q;
        rdata[DOZE_BIT]  = doze_q;
    end

    assign dpm_en     = dpm_q;
    assign want_sleep = sleep_q;
    assign want_nap   = nap_q & ~sleep_q;
    assign want_doze  = doze_q & ~nap_q & ~sleep_q;
endmodule

// File: rtl/pms_delay_cnt.sv
module pms_delay_cnt #(
    parameter int DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (DLY < 2) ? 1 : $clog2(DLY);
    localparam logic [CW-1:0] LAST = CW'(DLY - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (!run || cnt_q == LAST) cnt_q <= '0;
        else                          cnt_q <= cnt_q + 1'b1;
    end

    assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/pms_clk_gate.sv
module pms_clk_gate
    import pms_pkg::*;
#(
    parameter int NUM_UNITS = 4
) (
    input  pwr_state_e           st,
    input  logic                 dpm_en,
    input  logic [NUM_UNITS-1:0] unit_busy,
    output logic [NUM_UNITS-1:0] unit_clk_en,
    output logic                 snoop_clk_en,
    output logic                 tb_clk_en,
    output logic                 dcache_en,
    output logic                 rcv_en,
    output logic                 clkregen_en,
    output logic                 qreq
);
    logic awake;

    always_comb begin
        awake        = 1'b0;
        snoop_clk_en = 1'b1;
        tb_clk_en    = 1'b1;
        dcache_en    = 1'b0;
        rcv_en       = 1'b1;
        clkregen_en  = 1'b1;
        qreq         = 1'b0;
        unique case (st)
            PS_FULL, PS_DOZE_ENTRY: begin
                awake     = 1'b1;
                dcache_en = 1'b1;
            end
            PS_QUIESCE, PS_LOW_ENTRY: begin
                awake     = 1'b1;
                dcache_en = 1'b1;
                qreq      = 1'b1;
            end
            PS_DOZE: ;
            PS_COPYBACK: dcache_en = 1'b1;
            PS_NAP: begin
                snoop_clk_en = 1'b0;
                rcv_en       = 1'b0;
                qreq         = 1'b1;
            end
            PS_SLEEP: begin
                snoop_clk_en = 1'b0;
                tb_clk_en    = 1'b0;
                rcv_en       = 1'b0;
                clkregen_en  = 1'b0;
                qreq         = 1'b1;
            end
        endcase
    end

    for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
        assign unit_clk_en[i] = awake & (~dpm_en | unit_busy[i]);
    end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pms_pkg::*;
#(
    parameter int NUM_UNITS = 4,
    parameter int ENTRY_DLY = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_rst,
    input  logic                 mode_we,
    input  logic [15:0]          mode_wdata,
    output logic [15:0]          mode_rdata,
    input  logic [NUM_UNITS-1:0] unit_busy,
    input  logic                 snoop_hit,
    input  logic                 copyback_done,
    input  logic                 irq_ext,
    input  logic                 irq_smi,
    input  logic                 irq_mchk,
    input  logic                 irq_dec,
    input  logic                 qack,
    output logic                 qreq,
    output logic [NUM_UNITS-1:0] unit_clk_en,
    output logic                 snoop_clk_en,
    output logic                 tb_clk_en,
    output logic                 dcache_en,
    output logic                 rcv_en,
    output logic                 clkregen_en,
    output logic                 tb_reload,
    output logic [2:0]           pwr_state
);
    pwr_state_e st_q, st_nxt;
    logic       wake, clr_req, dly_done, dly_run;
    logic       dpm_en, want_doze, want_nap, want_sleep;
    logic       tgt_sleep_q, reload_q;

    assign wake    = irq_ext | irq_smi | irq_mchk | irq_dec | soft_rst;
    assign dly_run = (st_q == PS_DOZE_ENTRY) || (st_q == PS_LOW_ENTRY);

    pms_req_reg u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (mode_we),
        .wdata      (mode_wdata),
        .clr_req    (clr_req),
        .rdata      (mode_rdata),
        .dpm_en     (dpm_en),
        .want_doze  (want_doze),
        .want_nap   (want_nap),
        .want_sleep (want_sleep)
    );

    pms_delay_cnt #(.DLY(ENTRY_DLY)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (dly_run),
        .done  (dly_done)
    );

    always_comb begin
        st_nxt  = st_q;
        clr_req = 1'b0;
        if (st_q != PS_FULL && wake) begin
            st_nxt  = PS_FULL;
            clr_req = 1'b1;
        end else begin
            unique case (st_q)
                PS_FULL: begin
                    if (soft_rst)                    clr_req = 1'b1;
                    else if (want_sleep || want_nap) st_nxt  = PS_QUIESCE;
                    else if (want_doze)              st_nxt  = PS_DOZE_ENTRY;
                end
                PS_DOZE_ENTRY: if (dly_done)      st_nxt = PS_DOZE;
                PS_DOZE:       if (snoop_hit)     st_nxt = PS_COPYBACK;
                PS_COPYBACK:   if (copyback_done) st_nxt = PS_DOZE;
                PS_QUIESCE:    if (qack)          st_nxt = PS_LOW_ENTRY;
                PS_LOW_ENTRY:  if (dly_done)      st_nxt = tgt_sleep_q ? PS_SLEEP : PS_NAP;
                PS_NAP, PS_SLEEP: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= PS_FULL;
            tgt_sleep_q <= 1'b0;
            reload_q    <= 1'b0;
        end else begin
            st_q <= st_nxt;
            if (st_q == PS_FULL && st_nxt == PS_QUIESCE) tgt_sleep_q <= want_sleep;
            if (st_q == PS_SLEEP && wake) reload_q <= 1'b1;
            else if (mode_we)             reload_q <= 1'b0;
        end
    end

    pms_clk_gate #(.NUM_UNITS(NUM_UNITS)) u_gate (
        .st           (st_q),
        .dpm_en       (dpm_en),
        .unit_busy    (unit_busy),
        .unit_clk_en  (unit_clk_en),
        .snoop_clk_en (snoop_clk_en),
        .tb_clk_en    (tb_clk_en),
        .dcache_en    (dcache_en),
        .rcv_en       (rcv_en),
        .clkregen_en  (clkregen_en),
        .qreq         (qreq)
    );

    assign tb_reload = reload_q;
    assign pwr_state = st_q;
endmodule

// File: rtl/pms_chk.sv
module pms_chk #(
    parameter int NUM_UNITS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 soft_rst,
    input logic                 irq_ext,
    input logic                 irq_smi,
    input logic                 irq_mchk,
    input logic                 irq_dec,
    input logic [15:0]          mode_rdata,
    input logic [NUM_UNITS-1:0] unit_busy,
    input logic [NUM_UNITS-1:0] unit_clk_en,
    input logic                 snoop_clk_en,
    input logic                 tb_clk_en,
    input logic                 dcache_en,
    input logic                 rcv_en,
    input logic                 clkregen_en,
    input logic                 qreq,
    input logic                 tb_reload,
    input logic [2:0]           pwr_state
);
    logic wake;
    assign wake = irq_ext | irq_smi | irq_mchk | irq_dec | soft_rst;

    a_r2_dpm_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd0 && mode_rdata[11]) |-> (unit_clk_en == unit_busy));

    a_r2_full_all_on: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd0 && !mode_rdata[11]) |-> (&unit_clk_en));

    a_r4_copyback_cache_on: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd3) |-> (dcache_en && snoop_clk_en));

    a_r5_nap_after_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd6 && $past(pwr_state) != 3'd6) |-> ($past(pwr_state) == 3'd5));

    a_r6_sleep_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd7) |-> (unit_clk_en == '0 && !snoop_clk_en && !tb_clk_en
                                 && !rcv_en && !clkregen_en && !dcache_en));

    a_r8_wake_to_full: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != 3'd0 && wake) |=> (pwr_state == 3'd0 && !qreq));

    a_r10_req_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != 3'd0 && wake) |=> (mode_rdata[10:8] == 3'b000));

    a_r11_reload_on_sleep_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd7 && wake) |=> tb_reload);

    a_r12_qreq_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state >= 3'd4) |-> qreq);
endmodule

bind pwr_mode_seq pms_chk #(.NUM_UNITS(NUM_UNITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (soft_rst),
    .irq_ext      (irq_ext),
    .irq_smi      (irq_smi),
    .irq_mchk     (irq_mchk),
    .irq_dec      (irq_dec),
    .mode_rdata   (mode_rdata),
    .unit_busy    (unit_busy),
    .unit_clk_en  (unit_clk_en),
    .snoop_clk_en (snoop_clk_en),
    .tb_clk_en    (tb_clk_en),
    .dcache_en    (dcache_en),
    .rcv_en       (rcv_en),
    .clkregen_en  (clkregen_en),
    .qreq         (qreq),
    .tb_reload    (tb_reload),
    .pwr_state    (pwr_state)
);

// File: tb/tb_pwr_mode_seq.sv
module tb_pwr_mode_seq;
    localparam int NU = 4;
    localparam int DLY = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 0, mode_we = 0, snoop_hit = 0, copyback_done = 0;
    logic irq_ext = 0, irq_smi = 0, irq_mchk = 0, irq_dec = 0, qack = 0;
    logic [15:0] mode_wdata = '0;
    logic [15:0] mode_rdata;
    logic [NU-1:0] unit_busy = '0;
    logic [NU-1:0] unit_clk_en;
    logic qreq, snoop_clk_en, tb_clk_en, dcache_en, rcv_en, clkregen_en, tb_reload;
    logic [2:0] pwr_state;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    pwr_mode_seq #(.NUM_UNITS(NU), .ENTRY_DLY(DLY)) dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .mode_we(mode_we),
        .mode_wdata(mode_wdata), .mode_rdata(mode_rdata), .unit_busy(unit_busy),
        .snoop_hit(snoop_hit), .copyback_done(copyback_done), .irq_ext(irq_ext),
        .irq_smi(irq_smi), .irq_mchk(irq_mchk), .irq_dec(irq_dec), .qack(qack),
        .qreq(qreq), .unit_clk_en(unit_clk_en), .snoop_clk_en(snoop_clk_en),
        .tb_clk_en(tb_clk_en), .dcache_en(dcache_en), .rcv_en(rcv_en),
        .clkregen_en(clkregen_en), .tb_reload(tb_reload), .pwr_state(pwr_state)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic write_mode(input logic [15:0] v);
        mode_we = 1'b1;
        mode_wdata = v;
        step();
        mode_we = 1'b0;
    endtask

    task automatic pulse_wake(input int src);
        case (src)
            0: irq_ext = 1'b1;
            1: irq_smi = 1'b1;
            2: irq_mchk = 1'b1;
            3: irq_dec = 1'b1;
            default: soft_rst = 1'b1;
        endcase
        step();
        {irq_ext, irq_smi, irq_mchk, irq_dec, soft_rst} = '0;
    endtask

    // packed output vector: {units, snoop, tb, dcache, rcv, regen, qreq}
    function automatic logic [31:0] outs();
        return {22'd0, unit_clk_en, snoop_clk_en, tb_clk_en, dcache_en, rcv_en, clkregen_en, qreq};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        check("R1 state", pwr_state, 0);
        check("R1 outputs", outs(), {22'd0, {NU{1'b1}}, 6'b111110});
        check("R1 mode reg", mode_rdata, 0);
        check("R1 tb_reload", tb_reload, 0);

        // R2 dynamic power management over every busy pattern
        write_mode(16'h0800);
        for (int b = 0; b < (1 << NU); b++) begin
            unit_busy = NU'(b);
            #1;
            check("R2 unit enables follow busy", unit_clk_en, b);
            check("R2 snoop/tb on", {snoop_clk_en, tb_clk_en}, 2'b11);
        end
        // R10 soft reset in FULL keeps bit 11
        write_mode(16'h0800);
        pulse_wake(4);
        check("R10 soft reset keeps dpm", mode_rdata[11:8], 4'b1000);
        unit_busy = '0;
        write_mode(16'h0000);
        check("R2 dpm off all on", unit_clk_en, {NU{1'b1}});

        // R3/R5/R6/R7/R8/R10/R11/R12 sweep of request patterns x wake sources
        for (int req = 1; req < 8; req++) begin
            for (int src = 0; src < 5; src++) begin
                automatic int tgt = req[2] ? 7 : (req[1] ? 6 : 2);
                write_mode({4'b0, 1'b1, 3'(req), 8'h00});
                step();
                if (tgt == 2) begin
                    check("R3 R7 doze entry", pwr_state, 1);
                    repeat (DLY - 1) step();
                    check("R3 entry delay held", pwr_state, 1);
                    step();
                    check("R3 doze state", pwr_state, 2);
                    check("R3 doze outputs", outs(), {22'd0, {NU{1'b0}}, 6'b110110});
                end else begin
                    check("R5 R7 quiesce", pwr_state, 4);
                    repeat (3) step();
                    check("R5 waits for qack", {pwr_state, qreq}, {3'd4, 1'b1});
                    qack = 1'b1;
                    step();
                    qack = 1'b0;
                    check("R12 low entry qreq", {pwr_state, qreq}, {3'd5, 1'b1});
                    repeat (DLY - 1) step();
                    check("R5 entry delay held", pwr_state, 5);
                    step();
                    check("R7 target state", pwr_state, tgt);
                    if (tgt == 6)
                        check("R5 nap outputs", outs(), {22'd0, {NU{1'b0}}, 6'b010011});
                    else
                        check("R6 sleep outputs", outs(), 32'd1);
                    step();
                    check("R12 qreq held", qreq, 1);
                end
                pulse_wake(src);
                check("R8 wake to full", {pwr_state, qreq}, {3'd0, 1'b0});
                check("R10 requests cleared", mode_rdata[11:8], 4'b1000);
                step();
                check("R11 reload flag", tb_reload, (tgt == 7));
                write_mode(16'h0000);
                check("R11 cleared by write", tb_reload, 0);
            end
        end

        // R9 abandon during quiesce for every wake source
        for (int src = 0; src < 5; src++) begin
            write_mode(16'h0200);
            step();
            check("R9 quiesce entered", pwr_state, 4);
            pulse_wake(src);
            check("R9 abandoned", {pwr_state, qreq}, {3'd0, 1'b0});
            check("R9 R10 bits cleared", mode_rdata[10:8], 0);
            step();
            check("R9 stays full", pwr_state, 0);
        end

        // R4 copy-back excursion
        write_mode(16'h0100);
        repeat (DLY + 1) step();
        check("R4 in doze", {pwr_state, dcache_en}, {3'd2, 1'b0});
        snoop_hit = 1'b1;
        step();
        snoop_hit = 1'b0;
        check("R4 copyback", {pwr_state, dcache_en, snoop_clk_en}, {3'd3, 2'b11});
        repeat (2) step();
        check("R4 waits done", pwr_state, 3);
        copyback_done = 1'b1;
        step();
        copyback_done = 1'b0;
        check("R4 back to doze", {pwr_state, dcache_en}, {3'd2, 1'b0});
        pulse_wake(3);
        check("R8 doze exit", pwr_state, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule